// File: doc/BRIEF.md
# Timer Channel Host Access Port

This block is the byte-wide register front end of one programmable counter channel. The host uses it to program the channel's operating mode, its count format flag and its byte access pattern through control words. It then loads a 16-bit start count one byte at a time, and reads the count back one byte at a time, either live or from a frozen snapshot. The counting engine sits outside this block. The engine supplies the live count and its output level, and it receives a one-cycle load pulse together with the assembled 16-bit value.

Control words with bits 7:6 equal to 2'b11 are read-back commands. Any other control word carries an access code in bits 5:4, the mode in bits 3:1 and the BCD flag in bit 0. An access code of 2'b00 means "snapshot the count" and does not reprogram the channel. Access codes are 2'b01 for low byte only, 2'b10 for high byte only, and 2'b11 for low byte followed by high byte.

Read data is combinational. `rdata` always shows the byte that the next read will return, and a pulse on `rd_en` consumes that byte. At most one of the three strobes is asserted in any cycle.

Top module: `cnt_host_if`

## Requirements
- R1: After reset, mode is 3, access is 2'b11 (word), BCD is 0, no status or count snapshot is pending, both byte sequences are at their first byte, and `load_pulse` is low.
- R2: A control word with bits 7:6 not 2'b11 and a non-zero bits 5:4 sets mode from bits 3:1, BCD from bit 0 and access from bits 5:4 at the next edge. It also returns both the read and the write byte sequences to their first byte, and it produces no load.
- R3: With access 2'b01, a data write loads {8'h00, byte}. With access 2'b10, a data write loads {byte, 8'h00}. `load_pulse` is high for exactly the one cycle after the write strobe, with `load_value` valid in that cycle.
- R4: With access 2'b11, the first data byte is held and produces no load. The second data byte loads {second, first}, and the sequence then returns to the first byte.
- R5: A control word with bits 7:6 not 2'b11 and bits 5:4 equal to 2'b00 captures the live count together with the current access code, but only if no count snapshot is pending. It leaves mode, access and BCD unchanged.
- R6: A snapshot taken under word access reads low byte, then high byte, and is then released. A snapshot taken under single-byte access returns its selected byte (low for 2'b01, high for 2'b10) and is released by that one read. While a snapshot is pending, changes of the live count are not visible.
- R7: A read-back command (bits 7:6 = 2'b11) requests a count snapshot when bit 5 is 0, under the rules of R5. It latches a status byte when bit 4 is 0 and no status is pending. A pending status is never overwritten.
- R8: The status byte is {output level at latch time, 1'b0, access[1:0], mode[2:0], BCD}, with the output level in bit 7 and BCD in bit 0.
- R9: A pending status byte is returned before any count snapshot, and reading it clears it. The snapshot remains for the reads that follow.
- R10: With nothing pending, a read under word access returns the low and high bytes of the live count in alternation, starting with the low byte. Under single-byte access, a read returns the selected byte of the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data_en | input | 1 | Data byte write strobe |
| wr_ctl_en | input | 1 | Control word write strobe |
| wdata | input | 8 | Write data for both strobes |
| rd_en | input | 1 | Read strobe; consumes the byte shown on `rdata` |
| live_count | input | 16 | Current count from the counting engine |
| out_level | input | 1 | Current output level from the counting engine |
| rdata | output | 8 | Byte returned by the next read |
| load_pulse | output | 1 | One-cycle count load request |
| load_value | output | 16 | Count value accompanying `load_pulse` |
| mode | output | 3 | Programmed operating mode |
| access | output | 2 | Programmed byte access code |
| bcd | output | 1 | Programmed BCD flag |

## Verification
Directed sequences cover the following cases:
- Each access code separately, for both loads and reads.
- A control word issued halfway through a word load, which separates a correct sequence rewind from a stale held byte.
- A second snapshot command that must be ignored.
- A status latched together with a count snapshot, which exposes read-ordering errors.
- A second status request that must not overwrite the first.

A long random mix of control words, data writes, reads and live-count changes then checks every read byte and every load against a bench model. The random mix includes changes of access code while a snapshot is pending, which separates a snapshot that keeps its own byte order from one that follows the current access code.

// File: rtl/tca_pkg.sv
package tca_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned ACC_W  = 2;

  // access codes; a snapshot state reuses the same code, 00 meaning "none"
  localparam logic [ACC_W-1:0] ACC_NONE = 2'b00;
  localparam logic [ACC_W-1:0] ACC_LO   = 2'b01;
  localparam logic [ACC_W-1:0] ACC_HI   = 2'b10;
  localparam logic [ACC_W-1:0] ACC_WORD = 2'b11;

  localparam logic [MODE_W-1:0] RESET_MODE = 3'd3;

  // count value for a single-byte load
  function automatic logic [CNT_W-1:0] f_single_load(input logic [ACC_W-1:0] acc,
                                                     input logic [BYTE_W-1:0] d);
    logic [CNT_W-1:0] v;
    v = '0;
    if (acc == ACC_HI) v[CNT_W-1:BYTE_W] = d;
    else               v[BYTE_W-1:0]     = d;
    return v;
  endfunction

  // count value from two bytes
  function automatic logic [CNT_W-1:0] f_join(input logic [BYTE_W-1:0] lo,
                                              input logic [BYTE_W-1:0] hi);
    return {hi, lo};
  endfunction

  // one byte of a count word
  function automatic logic [BYTE_W-1:0] f_pick(input logic [CNT_W-1:0] w, input logic hi);
    return hi ? w[CNT_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  // status byte: level, zero, access, mode, bcd
  function automatic logic [BYTE_W-1:0] f_status(input logic lvl,
                                                 input logic [ACC_W-1:0] acc,
                                                 input logic [MODE_W-1:0] m,
                                                 input logic b);
    return {lvl, 1'b0, acc, m, b};
  endfunction

endpackage

// File: rtl/tca_ctl_decode.sv
module tca_ctl_decode
  import tca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic [BYTE_W-1:0] cw,
  output logic [MODE_W-1:0] mode,
  output logic [ACC_W-1:0]  access,
  output logic              bcd,
  output logic              ev_prog,
  output logic              ev_cnt_req,
  output logic              ev_stat_req
);

  logic is_rb;
  logic is_snap;
  logic [ACC_W-1:0] cw_acc;

  assign cw_acc = cw[5:4];

  always_comb begin
    is_rb       = ctl_en && (cw[7:6] == 2'b11);
    is_snap     = ctl_en && !is_rb && (cw_acc == ACC_NONE);
    ev_prog     = ctl_en && !is_rb && (cw_acc != ACC_NONE);
    ev_cnt_req  = is_snap || (is_rb && !cw[5]);
    ev_stat_req = is_rb && !cw[4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= RESET_MODE;
      access <= ACC_WORD;
      bcd    <= 1'b0;
    end else if (ev_prog) begin
      mode   <= cw[3:1];
      access <= cw_acc;
      bcd    <= cw[0];
    end
  end

  a_r2_fields_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> (mode == $past(cw[3:1])) && (access == $past(cw[5:4])) && (bcd == $past(cw[0])));

  a_r5_snapshot_keeps_program: assert property (@(posedge clk) disable iff (!rst_n)
    is_snap |=> $stable(mode) && $stable(access) && $stable(bcd));

  a_r2_access_never_none: assert property (@(posedge clk) disable iff (!rst_n)
    access != ACC_NONE);

endmodule

// File: rtl/tca_wr_seq.sv
module tca_wr_seq
  import tca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ACC_W-1:0]  access,
  input  logic              seq_clr,
  output logic              load_pulse,
  output logic [CNT_W-1:0]  load_value
);

  logic              wr_hi;
  logic [BYTE_W-1:0] held;
  logic              first_word_byte;

  assign first_word_byte = wr_en && (access == ACC_WORD) && !wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hi      <= 1'b0;
      held       <= '0;
      load_pulse <= 1'b0;
      load_value <= '0;
    end else begin
      load_pulse <= 1'b0;
      if (seq_clr) begin
        wr_hi <= 1'b0;
      end else if (wr_en) begin
        case (access)
          ACC_LO, ACC_HI: begin
            load_pulse <= 1'b1;
            load_value <= f_single_load(access, wdata);
          end
          ACC_WORD: begin
            if (!wr_hi) begin
              held  <= wdata;
              wr_hi <= 1'b1;
            end else begin
              load_pulse <= 1'b1;
              load_value <= f_join(held, wdata);
              wr_hi      <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> $past(wr_en));

  a_r3_single_byte_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !seq_clr && (access != ACC_WORD)) |=> load_pulse);

  a_r4_first_byte_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (first_word_byte && !seq_clr) |=> !load_pulse && wr_hi);

  a_r4_second_byte_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !seq_clr && (access == ACC_WORD) && wr_hi) |=> load_pulse && !wr_hi);

  a_r2_prog_rewinds_write: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clr |=> !wr_hi && !load_pulse);

endmodule

// File: rtl/tca_rd_path.sv
module tca_rd_path
  import tca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              cnt_req,
  input  logic              stat_req,
  input  logic              seq_clr,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              out_level,
  input  logic [ACC_W-1:0]  access,
  input  logic [MODE_W-1:0] mode,
  input  logic              bcd,
  output logic [BYTE_W-1:0] rdata
);

  logic [ACC_W-1:0]  snap_code;
  logic [CNT_W-1:0]  snap_val;
  logic              st_pend;
  logic [BYTE_W-1:0] st_val;
  logic              rd_hi;

  // named events
  logic rd_stat, rd_snap, rd_live, snap_take, stat_take;

  assign rd_stat   = rd_en && st_pend;
  assign rd_snap   = rd_en && !st_pend && (snap_code != ACC_NONE);
  assign rd_live   = rd_en && !st_pend && (snap_code == ACC_NONE);
  assign snap_take = cnt_req && (snap_code == ACC_NONE);
  assign stat_take = stat_req && !st_pend;

  always_comb begin
    if (st_pend) begin
      rdata = st_val;
    end else begin
      case (snap_code)
        ACC_LO, ACC_WORD: rdata = f_pick(snap_val, 1'b0);
        ACC_HI:           rdata = f_pick(snap_val, 1'b1);
        default: begin
          case (access)
            ACC_HI:   rdata = f_pick(live_count, 1'b1);
            ACC_WORD: rdata = f_pick(live_count, rd_hi);
            default:  rdata = f_pick(live_count, 1'b0);
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_code <= ACC_NONE;
      snap_val  <= '0;
    end else if (snap_take) begin
      snap_code <= access;
      snap_val  <= live_count;
    end else if (rd_snap) begin
      snap_code <= (snap_code == ACC_WORD) ? ACC_HI : ACC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pend <= 1'b0;
      st_val  <= '0;
    end else if (stat_take) begin
      st_pend <= 1'b1;
      st_val  <= f_status(out_level, access, mode, bcd);
    end else if (rd_stat) begin
      st_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi <= 1'b0;
    end else if (seq_clr) begin
      rd_hi <= 1'b0;
    end else if (rd_live && (access == ACC_WORD)) begin
      rd_hi <= !rd_hi;
    end
  end

  a_r9_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !st_pend);

  a_r9_status_shadows_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !cnt_req) |=> $stable(snap_code));

  a_r7_status_not_overwritten: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pend && !rd_en) |=> st_pend && $stable(st_val));

  a_r5_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((snap_code != ACC_NONE) && !rd_snap) |=> $stable(snap_val) && $stable(snap_code));

  a_r6_word_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_snap && (snap_code == ACC_WORD)) |=> (snap_code == ACC_HI));

  a_r6_single_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_snap && (snap_code != ACC_WORD)) |=> (snap_code == ACC_NONE));

  a_r10_word_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && !seq_clr && (access == ACC_WORD)) |=> (rd_hi != $past(rd_hi)));

endmodule

// File: rtl/cnt_host_if.sv
module cnt_host_if
  import tca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_en,
  input  logic              wr_ctl_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              out_level,
  output logic [BYTE_W-1:0] rdata,
  output logic              load_pulse,
  output logic [CNT_W-1:0]  load_value,
  output logic [MODE_W-1:0] mode,
  output logic [ACC_W-1:0]  access,
  output logic              bcd
);

  logic ev_prog, ev_cnt_req, ev_stat_req;

  tca_ctl_decode u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (wr_ctl_en),
    .cw         (wdata),
    .mode       (mode),
    .access     (access),
    .bcd        (bcd),
    .ev_prog    (ev_prog),
    .ev_cnt_req (ev_cnt_req),
    .ev_stat_req(ev_stat_req)
  );

  tca_wr_seq u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_data_en),
    .wdata     (wdata),
    .access    (access),
    .seq_clr   (ev_prog),
    .load_pulse(load_pulse),
    .load_value(load_value)
  );

  tca_rd_path u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .cnt_req   (ev_cnt_req),
    .stat_req  (ev_stat_req),
    .seq_clr   (ev_prog),
    .live_count(live_count),
    .out_level (out_level),
    .access    (access),
    .mode      (mode),
    .bcd       (bcd),
    .rdata     (rdata)
  );

  a_r1_no_load_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data_en) |=> !load_pulse);

endmodule

// File: tb/cnt_host_if_tb.sv
module cnt_host_if_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_data_en = 1'b0, wr_ctl_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [15:0] live_count = 16'h0000;
  logic        out_level = 1'b0;
  logic [7:0]  rdata;
  logic        load_pulse;
  logic [15:0] load_value;
  logic [2:0]  mode;
  logic [1:0]  access;
  logic        bcd;

  always #10 clk = ~clk;

  cnt_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data_en(wr_data_en), .wr_ctl_en(wr_ctl_en),
    .wdata(wdata), .rd_en(rd_en), .live_count(live_count), .out_level(out_level),
    .rdata(rdata), .load_pulse(load_pulse), .load_value(load_value),
    .mode(mode), .access(access), .bcd(bcd)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [2:0]  m_mode;
  logic [1:0]  m_acc;
  logic        m_bcd, m_whi, m_rhi, m_sp;
  logic [7:0]  m_held, m_st;
  logic [1:0]  m_cl;
  logic [15:0] m_lat;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic lvl, input logic [1:0] a,
                                            input logic [2:0] m, input logic b);
    return 8'((int'(lvl) * 128) + (int'(a) * 16) + (int'(m) * 2) + int'(b));
  endfunction

  function automatic logic [7:0] lo_of(input logic [15:0] w); return 8'(w % 256); endfunction
  function automatic logic [7:0] hi_of(input logic [15:0] w); return 8'(w / 256); endfunction

  task automatic m_snap();
    if (m_cl == 2'b00) begin m_lat = live_count; m_cl = m_acc; end
  endtask

  task automatic do_ctl(input logic [7:0] cw);
    string tag;
    @(negedge clk);
    wdata = cw; wr_ctl_en = 1'b1;
    @(negedge clk);
    wr_ctl_en = 1'b0;
    if (cw[7:6] == 2'b11) begin
      tag = "R7";
      if (!cw[5]) m_snap();
      if (!cw[4] && !m_sp) begin m_st = exp_status(out_level, m_acc, m_mode, m_bcd); m_sp = 1'b1; end
    end else if (cw[5:4] == 2'b00) begin
      tag = "R5";
      m_snap();
    end else begin
      tag = "R2";
      m_mode = cw[3:1]; m_acc = cw[5:4]; m_bcd = cw[0]; m_whi = 1'b0; m_rhi = 1'b0;
    end
    check({tag, " mode"}, 16'(mode), 16'(m_mode));
    check({tag, " access"}, 16'(access), 16'(m_acc));
    check({tag, " bcd"}, 16'(bcd), 16'(m_bcd));
    check({tag, " no load"}, 16'(load_pulse), 16'd0);
  endtask

  task automatic do_wr(input logic [7:0] d);
    logic        ep;
    logic [15:0] ev;
    string tag;
    @(negedge clk);
    wdata = d; wr_data_en = 1'b1;
    @(negedge clk);
    wr_data_en = 1'b0;
    ep = 1'b0; ev = 16'h0;
    if (m_acc == 2'b01) begin tag = "R3"; ep = 1'b1; ev = 16'(d); end
    else if (m_acc == 2'b10) begin tag = "R3"; ep = 1'b1; ev = 16'(d) * 16'd256; end
    else begin
      tag = "R4";
      if (!m_whi) begin m_held = d; m_whi = 1'b1; end
      else begin ep = 1'b1; ev = 16'(d) * 16'd256 + 16'(m_held); m_whi = 1'b0; end
    end
    check({tag, " load_pulse"}, 16'(load_pulse), 16'(ep));
    if (ep) check({tag, " load_value"}, load_value, ev);
    @(negedge clk);
    check({tag, " pulse one cycle"}, 16'(load_pulse), 16'd0);
  endtask

  task automatic do_rd();
    logic [7:0] e;
    string tag;
    @(negedge clk);
    rd_en = 1'b1;
    #2;
    if (m_sp) begin tag = "R9"; e = m_st; m_sp = 1'b0; end
    else if (m_cl != 2'b00) begin
      tag = "R6";
      if (m_cl == 2'b10) begin e = hi_of(m_lat); m_cl = 2'b00; end
      else begin e = lo_of(m_lat); m_cl = (m_cl == 2'b11) ? 2'b10 : 2'b00; end
    end else begin
      tag = "R10";
      if (m_acc == 2'b10) e = hi_of(live_count);
      else if (m_acc == 2'b01) e = lo_of(live_count);
      else begin e = m_rhi ? hi_of(live_count) : lo_of(live_count); m_rhi = !m_rhi; end
    end
    check({tag, " rdata"}, 16'(rdata), 16'(e));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_live(input logic [15:0] v, input logic o);
    @(negedge clk);
    live_count = v; out_level = o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_mode = 3'd3; m_acc = 2'b11; m_bcd = 1'b0; m_whi = 1'b0; m_rhi = 1'b0;
    m_sp = 1'b0; m_held = 8'h0; m_st = 8'h0; m_cl = 2'b00; m_lat = 16'h0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 mode", 16'(mode), 16'd3);
    check("R1 access", 16'(access), 16'd3);
    check("R1 bcd", 16'(bcd), 16'd0);
    check("R1 load_pulse", 16'(load_pulse), 16'd0);
    set_live(16'hA55A, 1'b0);
    do_rd(); do_rd();                       // R10 word alternation from reset
    do_wr(8'h34); do_wr(8'h12);             // R4 word load 1234
    do_ctl(8'h12); do_wr(8'h77);            // R2, R3 low-byte only
    do_ctl(8'h24); do_wr(8'h9C);            // R3 high-byte only
    do_ctl(8'h37); do_wr(8'hAA);            // start a word load
    do_ctl(8'h37); do_wr(8'h11); do_wr(8'h22); // R2 rewind: expect 2211
    // R5/R6 snapshot, second command ignored
    set_live(16'hBEEF, 1'b0); do_ctl(8'h00);
    set_live(16'h1111, 1'b0); do_ctl(8'h00);
    do_rd(); do_rd(); do_rd();
    // R7/R8/R9 status with snapshot; second status request ignored
    set_live(16'h4321, 1'b1); do_ctl(8'hC0);
    check("R8 status byte", 16'(m_st), 16'h00B7);
    set_live(16'h2222, 1'b0); do_ctl(8'hE0);
    do_rd(); do_rd(); do_rd();
    // R6 high-byte snapshot released by one read
    do_ctl(8'h20); set_live(16'h5A3C, 1'b0); do_ctl(8'h00);
    set_live(16'h0000, 1'b0); do_rd(); do_rd();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 2) set_live(16'($urandom), 1'($urandom));
      else if (op < 4) do_ctl(8'($urandom));
      else if (op < 6) do_wr(8'($urandom));
      else do_rd();
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule